// File: doc/BRIEF.md
# Equalizer zero-lock tuning controller

This block tunes the receive equalizer of an attached line transceiver by sampling and then pinning its adaptive "zero" setting. It is advanced by a slow periodic tick, typically about one per second. Each tick moves it at most one step, and each step can issue a few accesses on a simple register read/write request port. When the link is up at 100 Mb/s and the block is enabled, it clears the equalizer register and collects a fixed number of samples of the 4-bit zero field into sixteen saturating bins.

If any sample landed in the upper range (0xB to 0xF), the most frequent value is written back with a lock flag. The block then discards the clear-on-read symbol error counter and waits a long interval. At the end of that interval it reads the error counter again. If the count is above a threshold it starts a new tuning round; if not, it waits another interval.

Losing the link forces the block back to its idle starting state between accesses. Every access is held with a stable address and data until the far side answers with a done strobe. No state moves on while an access is outstanding.

Top module: `eq_zero_tuner`

## Requirements
- R1: After reset the block is in its idle starting state with no request outstanding (`req_valid_o` low).
- R2: In the starting state, a tick produces no access unless `enable_i`, `link_up_i` and `speed_100_i` are all high.
- R3: A qualifying tick in the starting state writes 0 to the equalizer address, clears all bins and the sample count, and then, on the same tick, reads the equalizer address as the first sample.
- R4: Each further tick while sampling issues exactly one read of the equalizer address; the zero value is read data bits [ZERO_LSB+3:ZERO_LSB], and other bits are ignored.
- R5: After SAMPLES samples with every value below 0xB, no write is made and the block returns to the starting state, so the next qualifying tick writes 0 again.
- R6: After SAMPLES samples with at least one value of 0xB or above, the block writes (1 << LOCK_BIT) | winner to the equalizer address. The winner is the value with the largest bin count; on a tie the lower value wins.
- R7: Straight after the lock write, the block reads the error counter address once, discards the result, and enters the waiting state.
- R8: In the waiting state, ticks 1 to SLEEP_TICKS-1 make no access. Tick SLEEP_TICKS reads the error counter. A value greater than `err_limit_i` returns the block to the starting state; any other value starts a new wait of SLEEP_TICKS ticks.
- R9: When `link_up_i` is low while no access is pending, the block goes to the starting state. A later qualifying tick restarts the round with cleared bins.
- R10: A request holds its valid, address and data unchanged until `req_done_i`. A tick that arrives while the block is mid-step is ignored.
- R11: Bins saturate at 2^BIN_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle step strobe |
| link_up_i | input | 1 | Link is established |
| speed_100_i | input | 1 | Link runs at 100 Mb/s |
| enable_i | input | 1 | Tuning permitted for this transceiver |
| err_limit_i | input | DATA_W | Error count above which tuning restarts |
| req_valid_o | output | 1 | Register access requested |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | ADDR_W | Register address |
| req_wdata_o | output | DATA_W | Write data |
| req_done_i | input | 1 | Access completed (one cycle) |
| req_rdata_i | input | DATA_W | Read data, valid with `req_done_i` |

## Verification
The bench builds the block with SAMPLES=20, BIN_W=3 and SLEEP_TICKS=4, and keeps the default register addresses and flag position. Twenty samples against seven-count bins let one round drive a bin past its ceiling. The chosen sample mix makes saturation and wrapping pick different winners. The four-tick wait brings both the pass and the fail outcomes of the error check within a few hundred cycles. The responder answers after a three-cycle latency, so hold behaviour and ticks that arrive mid-step are both exercised.

// File: rtl/eqz_pkg.sv
// Shared types for the equalizer zero-lock tuner.
// Assumes: nothing beyond the enums below.
package eqz_pkg;

    // Coarse tuning state, as seen across ticks.
    typedef enum logic [1:0] {
        ST_INITIAL  = 2'd0,
        ST_READING  = 2'd1,
        ST_SLEEPING = 2'd2
    } tune_state_t;

    // Fine step inside one tick: idle, or an access / decision in flight.
    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_CLEAR_WR  = 3'd1,
        PH_SAMPLE_RD = 3'd2,
        PH_DECIDE    = 3'd3,
        PH_LOCK_WR   = 3'd4,
        PH_FLUSH_RD  = 3'd5,
        PH_ERR_RD    = 3'd6
    } step_t;

endpackage

// File: rtl/eqz_req_port.sv
// Register-access request holder.
// Raises a request when the sequencer asks for one and none is pending.
// It latches address, data and direction, holds them until done, then
// returns an ack pulse. Assumes done arrives only while valid is high.
module eqz_req_port #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              done_i,
    output logic              valid_o,
    output logic              write_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ack_o
);

    logic              valid_q;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Issue a new request, or retire the pending one on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (valid_q) begin
            if (done_i) valid_q <= 1'b0;
        end else if (want_i) begin
            valid_q <= 1'b1;
            write_q <= write_i;
            addr_q  <= addr_i;
            data_q  <= data_i;
        end
    end

    // Drive the port and hand completion back to the sequencer.
    always_comb begin
        valid_o = valid_q;
        write_o = write_q;
        addr_o  = addr_q;
        data_o  = data_q;
        ack_o   = valid_q & done_i;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !done_i) |=> (valid_q && $stable(addr_q) && $stable(data_q) && $stable(write_q))) // R10
        else $error("request changed before done");

endmodule

// File: rtl/eqz_zero_hist.sv
// Sixteen-bin histogram of the sampled equalizer zero value.
// Counts samples, flags any hit in bins 0xB..0xF, and picks the most
// frequent value, with the lower index winning a tie.
// Assumes: clear and increment are never asserted together.
module eqz_zero_hist #(
    parameter int SAMPLES = 100,
    parameter int BIN_W   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       inc_i,
    input  logic [3:0] value_i,
    output logic       full_o,
    output logic       high_seen_o,
    output logic [3:0] best_o
);

    localparam int                NBINS   = 16;
    localparam int                CNT_W   = $clog2(SAMPLES + 1);
    localparam logic [BIN_W-1:0]  BIN_MAX = {BIN_W{1'b1}};
    localparam logic [CNT_W-1:0]  CNT_END = CNT_W'(SAMPLES);

    logic [BIN_W-1:0] bin_q [NBINS];
    logic [CNT_W-1:0] cnt_q;

    // Sample counter: cleared at round start, bumped per sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (inc_i)        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        // One saturating bin.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)
                bin_q[b] <= '0;
            else if (inc_i && value_i == 4'(b) && bin_q[b] != BIN_MAX)
                bin_q[b] <= bin_q[b] + 1'b1;
        end

        AST_BIN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
            (bin_q[b] == BIN_MAX && !clear_i) |=> (bin_q[b] == BIN_MAX)) // R11
            else $error("bin wrapped");
    end

    // Running maximum from bin 0 upward; only a strictly larger count wins.
    always_comb begin
        logic [BIN_W-1:0] top;
        top    = bin_q[0];
        best_o = 4'd0;
        for (int i = 1; i < NBINS; i++) begin
            if (bin_q[i] > top) begin
                top    = bin_q[i];
                best_o = 4'(i);
            end
        end
    end

    // Flag a completed round and any upper-range hit.
    always_comb begin
        full_o      = (cnt_q == CNT_END);
        high_seen_o = 1'b0;
        for (int i = 11; i < NBINS; i++)
            if (bin_q[i] != '0) high_seen_o = 1'b1;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CNT_END)) // R5
        else $error("sample count past end");

endmodule

// File: rtl/eqz_sleep_timer.sv
// Tick counter for the waiting interval.
// Flags the tick that completes the interval.
// Assumes: the sequencer clears it on entry and on expiry.
module eqz_sleep_timer #(
    parameter int TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic adv_i,
    output logic last_o
);

    localparam int               CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count ticks spent waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (adv_i)        cnt_q <= cnt_q + 1'b1;
    end

    // The next tick ends the interval.
    always_comb last_o = (cnt_q == LAST);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= LAST)) // R8
        else $error("sleep timer overran");

endmodule

// File: rtl/eq_zero_tuner.sv
// Equalizer zero-lock tuning sequencer (top).
// Each accepted tick starts one step, made of zero or more register
// accesses. Ticks arriving while a step is in flight are dropped.
// Assumes: req_done_i pulses only in answer to req_valid_o; read data is
// valid in the same cycle as done.
module eq_zero_tuner
    import eqz_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int EQ_ADDR     = 26,
    parameter int ERR_ADDR    = 21,
    parameter int LOCK_BIT    = 15,
    parameter int ZERO_LSB    = 4,
    parameter int SAMPLES     = 100,
    parameter int BIN_W       = 7,
    parameter int SLEEP_TICKS = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              link_up_i,
    input  logic              speed_100_i,
    input  logic              enable_i,
    input  logic [DATA_W-1:0] err_limit_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              req_done_i,
    input  logic [DATA_W-1:0] req_rdata_i
);

    localparam logic [ADDR_W-1:0] A_EQ   = ADDR_W'(EQ_ADDR);
    localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(ERR_ADDR);
    localparam logic [DATA_W-1:0] F_LOCK = DATA_W'(1) << LOCK_BIT;

    tune_state_t       state_q;
    step_t             step_q;
    logic              qualify;
    logic              acc_ack;
    logic              want, want_wr;
    logic [ADDR_W-1:0] want_addr;
    logic [DATA_W-1:0] want_data;
    logic              hist_clear, hist_inc, hist_full, hist_high;
    logic [3:0]        hist_best;
    logic              sleep_tick, tmr_clear, tmr_adv, tmr_last;

    // Conditions that allow a round to start.
    always_comb qualify = enable_i & link_up_i & speed_100_i;

    // Map the current step to the access it needs.
    always_comb begin
        want      = 1'b0;
        want_wr   = 1'b0;
        want_addr = A_EQ;
        want_data = '0;
        unique case (step_q)
            PH_CLEAR_WR:  begin want = 1'b1; want_wr = 1'b1; end
            PH_SAMPLE_RD: begin want = 1'b1; end
            PH_LOCK_WR:   begin want = 1'b1; want_wr = 1'b1;
                                want_data = F_LOCK | DATA_W'(hist_best); end
            PH_FLUSH_RD,
            PH_ERR_RD:    begin want = 1'b1; want_addr = A_ERR; end
            default:      ;
        endcase
    end

    // Strobes for the histogram and the timer.
    always_comb begin
        hist_clear = (step_q == PH_IDLE) && (state_q == ST_INITIAL) && tick_i && qualify;
        hist_inc   = (step_q == PH_SAMPLE_RD) && acc_ack;
        sleep_tick = (step_q == PH_IDLE) && (state_q == ST_SLEEPING) && link_up_i && tick_i;
        tmr_adv    = sleep_tick && !tmr_last;
        tmr_clear  = (sleep_tick && tmr_last)
                   || ((step_q == PH_FLUSH_RD) && acc_ack)
                   || ((step_q == PH_IDLE) && !link_up_i);
    end

    // Sequencer: coarse state across ticks, step within a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INITIAL;
            step_q  <= PH_IDLE;
        end else begin
            unique case (step_q)
                PH_IDLE: begin
                    if (!link_up_i) begin
                        state_q <= ST_INITIAL;
                    end else if (tick_i) begin
                        unique case (state_q)
                            ST_INITIAL: if (qualify) begin
                                state_q <= ST_READING;
                                step_q  <= PH_CLEAR_WR;
                            end
                            ST_READING:  step_q <= PH_SAMPLE_RD;
                            ST_SLEEPING: if (tmr_last) step_q <= PH_ERR_RD;
                            default:     state_q <= ST_INITIAL;
                        endcase
                    end
                end
                PH_CLEAR_WR:  if (acc_ack) step_q <= PH_SAMPLE_RD;
                PH_SAMPLE_RD: if (acc_ack) step_q <= PH_DECIDE;
                PH_DECIDE: begin
                    if (hist_full && hist_high) begin
                        step_q <= PH_LOCK_WR;
                    end else begin
                        step_q <= PH_IDLE;
                        if (hist_full) state_q <= ST_INITIAL;
                    end
                end
                PH_LOCK_WR:   if (acc_ack) step_q <= PH_FLUSH_RD;
                PH_FLUSH_RD:  if (acc_ack) begin
                    step_q  <= PH_IDLE;
                    state_q <= ST_SLEEPING;
                end
                PH_ERR_RD:    if (acc_ack) begin
                    step_q <= PH_IDLE;
                    if (req_rdata_i > err_limit_i) state_q <= ST_INITIAL;
                end
                default: step_q <= PH_IDLE;
            endcase
        end
    end

    eqz_req_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_i  (want),
        .write_i (want_wr),
        .addr_i  (want_addr),
        .data_i  (want_data),
        .done_i  (req_done_i),
        .valid_o (req_valid_o),
        .write_o (req_write_o),
        .addr_o  (req_addr_o),
        .data_o  (req_wdata_o),
        .ack_o   (acc_ack)
    );

    eqz_zero_hist #(.SAMPLES(SAMPLES), .BIN_W(BIN_W)) hist_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (hist_clear),
        .inc_i       (hist_inc),
        .value_i     (req_rdata_i[ZERO_LSB +: 4]),
        .full_o      (hist_full),
        .high_seen_o (hist_high),
        .best_o      (hist_best)
    );

    eqz_sleep_timer #(.TICKS(SLEEP_TICKS)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .adv_i   (tmr_adv),
        .last_o  (tmr_last)
    );

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_q == PH_IDLE) || (step_q == PH_DECIDE)) |-> !req_valid_o) // R10
        else $error("request outside an access step");

    AST_LOCK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == PH_LOCK_WR) |-> (hist_high && hist_full)) // R6
        else $error("lock without upper-range sample");

    AST_SLEEP_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEPING && $past(state_q) != ST_SLEEPING) |-> ($past(step_q) == PH_FLUSH_RD)) // R7
        else $error("entered wait without flush read");

    AST_LINK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == PH_IDLE && !link_up_i) |=> (state_q == ST_INITIAL)) // R9
        else $error("link loss did not restart");

endmodule

// File: tb/eq_zero_tuner_tb_top.sv
// Directed bench for the zero-lock tuner; one task per scenario.
module eq_zero_tuner_tb_top;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int EQA    = 26;
    localparam int ERRA   = 21;
    localparam int NSMP   = 20;
    localparam int LAT    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0, link = 1'b0, spd = 1'b0, en = 1'b0;
    logic [DATA_W-1:0] limit = 16'd300;
    logic              req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              req_done = 1'b0;
    logic [DATA_W-1:0] req_rdata = '0;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // Responder state and access log.
    logic [3:0]        sample_mem [256];
    int                rd_idx = 0, stage_ptr = 0;
    logic [DATA_W-1:0] err_val = '0;
    int                wait_cnt = 0;
    logic [ADDR_W-1:0] first_addr = '0;
    logic [DATA_W-1:0] first_data = '0;
    int                hold_bad = 0;
    logic              log_wr   [512];
    logic [ADDR_W-1:0] log_addr [512];
    logic [DATA_W-1:0] log_data [512];
    int                log_n = 0;

    always #2.5ns clk = ~clk;

    eq_zero_tuner #(.SAMPLES(NSMP), .BIN_W(3), .SLEEP_TICKS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .link_up_i(link),
        .speed_100_i(spd), .enable_i(en), .err_limit_i(limit),
        .req_valid_o(req_valid), .req_write_o(req_write), .req_addr_o(req_addr),
        .req_wdata_o(req_wdata), .req_done_i(req_done), .req_rdata_i(req_rdata));

    // Register-side model: answers after LAT cycles and logs each access.
    always @(posedge clk) begin
        if (req_valid && !req_done) begin
            if (wait_cnt == 0) begin
                first_addr <= req_addr;
                first_data <= req_wdata;
            end else if (req_addr != first_addr || req_wdata != first_data) begin
                hold_bad <= hold_bad + 1;
            end
            if (wait_cnt == LAT - 1) begin
                wait_cnt <= 0;
                req_done <= 1'b1;
                log_wr[log_n % 512]   <= req_write;
                log_addr[log_n % 512] <= req_addr;
                log_data[log_n % 512] <= req_wdata;
                log_n <= log_n + 1;
                if (!req_write && req_addr == ADDR_W'(EQA)) begin
                    req_rdata <= (16'h5A0F & 16'hFF0F) | {8'h00, sample_mem[rd_idx % 256], 4'h0};
                    rd_idx <= rd_idx + 1;
                end else begin
                    req_rdata <= err_val;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            req_done <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic stage(input logic [3:0] v);
        sample_mem[stage_ptr % 256] = v;
        stage_ptr++;
    endtask

    // One tick pulse, then let the step finish; returns accesses made.
    task automatic do_tick(output int base, output int n);
        base = log_n;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (40) @(negedge clk);
        n = log_n - base;
    endtask

    task automatic check_acc(input int k, input bit wr, input int addr, input int data, input string req);
        check(log_wr[k % 512] == wr && log_addr[k % 512] == ADDR_W'(addr) &&
              (!wr || log_data[k % 512] == DATA_W'(data)), req,
              {log_wr[k % 512], 3'b0, log_addr[k % 512], log_data[k % 512]},
              {wr, 3'b0, ADDR_W'(addr), DATA_W'(data)});
    endtask

    // Ticks 2..NSMP-1 of a round: one equalizer read each.
    task automatic mid_samples(input int count);
        int b, n;
        for (int i = 0; i < count; i++) begin
            do_tick(b, n);
            if (i == 0) begin
                check(n == 1, "R4 one access per sampling tick", n, 1);
                check_acc(b, 1'b0, EQA, 0, "R4 sampling read");
            end else if (n != 1) begin
                check(1'b0, "R4 one access per sampling tick", n, 1);
            end
        end
    endtask

    task automatic t_reset_and_gating();
        int b, n;
        check(req_valid == 1'b0, "R1 no request after reset", req_valid, 0);
        link = 1'b0; spd = 1'b1; en = 1'b1;
        do_tick(b, n);
        check(n == 0, "R2 link down", n, 0);
        link = 1'b1; spd = 1'b0;
        do_tick(b, n);
        check(n == 0, "R2 10 Mb/s", n, 0);
        spd = 1'b1; en = 1'b0;
        do_tick(b, n);
        check(n == 0, "R2 disabled", n, 0);
        en = 1'b1;
    endtask

    // Tie between 0x7 and 0xC at six each; lower wins.
    task automatic t_round_tie();
        int b, n;
        logic [3:0] rest [8] = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9};
        for (int i = 0; i < 6; i++) begin stage(4'hC); stage(4'h7); end
        for (int i = 0; i < 8; i++) stage(rest[i]);
        do_tick(b, n);
        check(n == 2, "R3 start tick access count", n, 2);
        check_acc(b, 1'b1, EQA, 0, "R3 clear write");
        check_acc(b + 1, 1'b0, EQA, 0, "R3 first sample read");
        mid_samples(NSMP - 2);
        do_tick(b, n);
        check(n == 3, "R6 final tick access count", n, 3);
        check_acc(b + 1, 1'b1, EQA, 16'h8007, "R6 lock tie lower index");
        check_acc(b + 2, 1'b0, ERRA, 0, "R7 flush read of error counter");
    endtask

    task automatic t_sleep();
        int b, n, tot;
        tot = 0;
        err_val = 16'd300;
        for (int i = 0; i < 3; i++) begin do_tick(b, n); tot += n; end
        check(tot == 0, "R8 quiet while waiting", tot, 0);
        do_tick(b, n);
        check(n == 1, "R8 error read at interval end", n, 1);
        check_acc(b, 1'b0, ERRA, 0, "R8 error read address");
        tot = 0;
        for (int i = 0; i < 3; i++) begin do_tick(b, n); tot += n; end
        check(tot == 0, "R8 equal to limit keeps waiting", tot, 0);
        err_val = 16'd301;
        do_tick(b, n);
        check(n == 1, "R8 second error read", n, 1);
        stage(4'hA);
        do_tick(b, n);
        check(n == 2 && log_wr[b % 512] == 1'b1, "R8 over limit restarts", n, 2);
    endtask

    task automatic t_low_round();
        int b, n;
        for (int i = 0; i < NSMP - 1; i++) stage(4'hA);
        mid_samples(NSMP - 2);
        do_tick(b, n);
        check(n == 1, "R5 no lock when nothing high", n, 1);
        stage(4'hF);
        do_tick(b, n);
        check(n == 2, "R5 back to start", n, 2);
        check_acc(b, 1'b1, EQA, 0, "R5 restart clear write");
    endtask

    task automatic t_link_drop();
        int b, n;
        stage(4'hF);
        do_tick(b, n);
        link = 1'b0;
        do_tick(b, n);
        check(n == 0, "R9 no access with link down", n, 0);
        link = 1'b1;
        stage(4'h2);
        do_tick(b, n);
        check(n == 2, "R9 restart after link return", n, 2);
        check_acc(b, 1'b1, EQA, 0, "R9 restart clear write");
        for (int i = 0; i < NSMP - 1; i++) stage(4'h2);
        mid_samples(NSMP - 2);
        do_tick(b, n);
        check(n == 1, "R9 bins cleared on restart", n, 1);
    endtask

    task automatic t_busy_and_saturate();
        int b, n;
        stage(4'hE);
        b = log_n;
        @(negedge clk) tick = 1'b1;
        @(negedge clk);
        @(negedge clk) tick = 1'b0;
        repeat (40) @(negedge clk);
        n = log_n - b;
        check(n == 2, "R10 tick mid-step ignored", n, 2);
        check(hold_bad == 0, "R10 request held until done", hold_bad, 0);
        for (int i = 0; i < 13; i++) stage(4'hE);
        for (int i = 0; i < 6; i++) stage(4'h5);
        mid_samples(NSMP - 2);
        do_tick(b, n);
        check(n == 3, "R11 lock after saturating round", n, 3);
        check_acc(b + 1, 1'b1, EQA, 16'h800E, "R11 saturated bin wins");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_gating();
        t_round_tie();
        t_sleep();
        t_low_round();
        t_link_drop();
        t_busy_and_saturate();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule